// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the control and status word that sits beside a floating-point datapath. It keeps the rounding mode, the precision and transfer-size modes and the signalling-NaN handling bit. It also keeps three exception fields:
- cause bits, which describe the most recent operation;
- enable bits, which select the exceptions that trap;
- sticky flag bits, which gather every exception since software last cleared them.

The datapath reports each operation start and every exception it raises. Software reads and writes the whole word. A trap request is raised while an enabled exception is recorded in the cause field.

The datapath drives `op_start` for one cycle when an operation begins, and this clears the cause field. Each exception is then reported on `exc_bits` for one cycle, and it sets the matching cause bit and flag bit. The error cause has no enable and no flag; whenever it is set, a trap is requested. Denormal handling is fixed to flush-to-zero, so that bit always reads 1. A build option removes error-cause support altogether. The read word and the trap request come from registers, so an input applied before a clock edge shows at the outputs right after that edge.

Top module: `fp_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset the word reads 0x00040001: round-to-zero mode, denormal bit set, everything else zero.
- R2: Bits 21 and 23 to 31 always read 0, whatever value is written.
- R3: Bit 18 (denormal mode) always reads 1; writing 0 to it has no effect.
- R4: A software write stores and reads back the following fields. Any other field is left untouched by a cycle without a write.
  - rounding mode in bits 1:0
  - flags in bits 6:2
  - enables in bits 11:7
  - cause in bits 17:12
  - precision in bit 19
  - transfer size in bit 20
  - NaN handling in bit 22

  The mode outputs show the stored rounding, precision, transfer and NaN bits.
- R5: A cycle with `op_start` high, no write and no exception leaves the cause field at zero.
- R6: `exc_bits` bit k reports one exception, in this order from bit 0: inexact, underflow, overflow, divide-by-zero, invalid, error. Exception k sets cause bit 12+k. For k below 5 it also sets flag bit 2+k. No other bit changes.
- R7: Flag bits stay set across operation starts and later exceptions, until a software write clears them.
- R8: When `op_start` and exceptions arrive in the same cycle, the cause field afterwards holds exactly those exceptions.
- R9: `trap_req` is high exactly when some cause bit among the first five is set together with its enable bit (enable bit 7+k for cause 12+k), or when the error cause (bit 17) is set.
- R10: The rounding codes 10 and 11 are reserved. They are stored as written and drive `round_reserved` high. Codes 00 (nearest) and 01 (zero) drive it low.
- R11: With error support disabled (`HAS_ERR` = 0), the error cause never sets, neither from `exc_bits` bit 5 nor from a write.
- R12: When a write and exceptions occur in the same cycle, the exceptions are ORed onto the written cause and flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write word |
| op_start | input | 1 | Operation-start pulse from the datapath |
| exc_bits | input | 6 | Exception events, one bit each (see R6) |
| rd_data | output | 32 | Current register word |
| trap_req | output | 1 | Enabled-exception trap request |
| round_reserved | output | 1 | A reserved rounding code is stored |
| cfg_round | output | 2 | Stored rounding mode |
| cfg_double | output | 1 | Stored precision bit |
| cfg_wide | output | 1 | Stored transfer-size bit |
| cfg_snan | output | 1 | Stored NaN-handling bit |

## Verification
The bench builds two copies of the block. The copy with `HAS_ERR` = 1 runs the vector walk: the error cause and its unconditional trap, every collision of write, start and exception, and reserved rounding codes. The copy with `HAS_ERR` = 0 receives error events and writes to the error cause bit, which brings the variant without error support within reach of R11. Its read word shows that the arithmetic exceptions are still recorded normally.

// File: rtl/fpsc_pkg.sv
// Package: field positions and shared types of the floating-point status word.
// Assumes a 32-bit word. Exception vectors hold bit 0 = inexact up to bit 5 = error.
package fpsc_pkg;
    localparam int WORD_W    = 32;
    localparam int RND_W     = 2;
    localparam int ARITH_N   = 5;               // exceptions that carry flag and enable
    localparam int EXC_N     = ARITH_N + 1;     // plus the error cause
    localparam int RND_LSB   = 0;
    localparam int FLAG_LSB  = RND_LSB + RND_W;
    localparam int EN_LSB    = FLAG_LSB + ARITH_N;
    localparam int CAUSE_LSB = EN_LSB + ARITH_N;
    localparam int DNRM_BIT  = CAUSE_LSB + EXC_N;
    localparam int PREC_BIT  = DNRM_BIT + 1;
    localparam int XFER_BIT  = PREC_BIT + 1;
    localparam int NAN_BIT   = XFER_BIT + 2;    // bit between transfer and NaN is reserved
    localparam logic [RND_W-1:0] RND_RESET = 2'b01;

    typedef logic [ARITH_N-1:0] arith_vec_t;
    typedef logic [EXC_N-1:0]   exc_vec_t;
endpackage

// File: rtl/fpsc_mode_reg.sv
// Mode register: rounding code, precision, transfer size and NaN handling.
// Assumes wr_en is a single-cycle write strobe. It flags reserved rounding codes.
module fpsc_mode_reg
    import fpsc_pkg::*;
#(
    parameter int RW = RND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_round,
    input  logic          wr_double,
    input  logic          wr_wide,
    input  logic          wr_snan,
    output logic [RW-1:0] round_q,
    output logic          double_q,
    output logic          wide_q,
    output logic          snan_q,
    output logic          round_rsv
);
    // Holds the mode fields; loads them on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_q  <= RW'(RND_RESET);
            double_q <= 1'b0;
            wide_q   <= 1'b0;
            snan_q   <= 1'b0;
        end else if (wr_en) begin
            round_q  <= wr_round;
            double_q <= wr_double;
            wide_q   <= wr_wide;
            snan_q   <= wr_snan;
        end
    end

    // Reserved codes are those with the top bit set (10 and 11).
    always_comb begin
        round_rsv = round_q[RW-1];
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(round_q) && $stable(double_q) && $stable(wide_q) && $stable(snan_q))); // R4
endmodule

// File: rtl/fpsc_exc_track.sv
// Exception tracker: cause, enable and sticky flag fields.
// Assumes exc_in events are single-cycle pulses. op_start clears cause before
// same-cycle events are merged, and a write is overlaid by same-cycle events.
module fpsc_exc_track
    import fpsc_pkg::*;
#(
    parameter bit HAS_ERR = 1'b1,
    parameter int AN      = ARITH_N,
    localparam int EN     = AN + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AN-1:0] wr_flag,
    input  logic [AN-1:0] wr_enable,
    input  logic [EN-1:0] wr_cause,
    input  logic          op_start,
    input  logic [EN-1:0] exc_in,
    output logic [AN-1:0] flag_q,
    output logic [AN-1:0] enable_q,
    output logic [EN-1:0] cause_q
);
    logic [EN-1:0] exc_eff;
    logic [EN-1:0] cause_base;
    logic [EN-1:0] cause_d;
    logic [AN-1:0] flag_d;

    // Error-support variant: keep or drop the error event and error cause.
    generate
        if (HAS_ERR) begin : g_err
            always_comb begin
                exc_eff = exc_in;
            end
        end else begin : g_no_err
            logic err_unused;
            always_comb begin
                exc_eff    = {1'b0, exc_in[AN-1:0]};
                err_unused = exc_in[EN-1] ^ wr_cause[EN-1];
            end
            AST_NO_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !cause_q[EN-1]); // R11
        end
    endgenerate

    // Next cause: start from the write or the held value, clear on op start, then merge events.
    always_comb begin
        cause_base = wr_en ? wr_cause : cause_q;
        if (op_start) begin
            cause_base = '0;
        end
        cause_d = cause_base | exc_eff;
        if (!HAS_ERR) begin
            cause_d[EN-1] = 1'b0;
        end
    end

    // Next flags: the write or the held value, with every arithmetic event accumulated.
    always_comb begin
        flag_d = (wr_en ? wr_flag : flag_q) | exc_eff[AN-1:0];
    end

    // State update for the three exception fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q  <= '0;
            flag_q   <= '0;
            enable_q <= '0;
        end else begin
            cause_q <= cause_d;
            flag_q  <= flag_d;
            if (wr_en) begin
                enable_q <= wr_enable;
            end
        end
    end

    AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !wr_en && (exc_in == '0)) |=> (cause_q == '0)); // R5
    AST_EXC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_eff != '0) |=> ((cause_q & $past(exc_eff)) == $past(exc_eff))); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7
endmodule

// File: rtl/fpsc_trap.sv
// Trap request: any arithmetic cause paired with its enable, or the error cause.
// Assumes cause and enable come straight from registers (purely combinational here).
module fpsc_trap
    import fpsc_pkg::*;
#(
    parameter int AN  = ARITH_N,
    localparam int EN = AN + 1
) (
    input  logic [EN-1:0] cause,
    input  logic [AN-1:0] enable,
    output logic          trap
);
    logic [AN-1:0] hit;

    // One AND gate per arithmetic exception.
    generate
        for (genvar k = 0; k < AN; k++) begin : g_hit
            always_comb begin
                hit[k] = cause[k] & enable[k];
            end
        end
    endgenerate

    // The error cause traps without an enable.
    always_comb begin
        trap = (|hit) | cause[EN-1];
    end
endmodule

// File: rtl/fp_status_ctrl.sv
// Top: floating-point status/control word with software access and datapath event input.
// Assumes synchronous active-low reset and single-cycle strobes. The read word is
// assembled from registers; reserved bits read 0 and the denormal bit reads 1.
module fp_status_ctrl
    import fpsc_pkg::*;
#(
    parameter bit HAS_ERR = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                op_start,
    input  logic [EXC_N-1:0]    exc_bits,
    output logic [WORD_W-1:0]   rd_data,
    output logic                trap_req,
    output logic                round_reserved,
    output logic [RND_W-1:0]    cfg_round,
    output logic                cfg_double,
    output logic                cfg_wide,
    output logic                cfg_snan
);
    arith_vec_t flag_q;
    arith_vec_t enable_q;
    exc_vec_t   cause_q;
    logic       wr_unused;

    // Sink for write bits that have no storage (reserved and denormal).
    always_comb begin
        wr_unused = ^{wr_data[WORD_W-1:NAN_BIT+1], wr_data[XFER_BIT+1], wr_data[DNRM_BIT]};
    end

    fpsc_mode_reg #(.RW(RND_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_round  (wr_data[RND_LSB +: RND_W]),
        .wr_double (wr_data[PREC_BIT]),
        .wr_wide   (wr_data[XFER_BIT]),
        .wr_snan   (wr_data[NAN_BIT]),
        .round_q   (cfg_round),
        .double_q  (cfg_double),
        .wide_q    (cfg_wide),
        .snan_q    (cfg_snan),
        .round_rsv (round_reserved)
    );

    fpsc_exc_track #(.HAS_ERR(HAS_ERR), .AN(ARITH_N)) u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_flag   (wr_data[FLAG_LSB +: ARITH_N]),
        .wr_enable (wr_data[EN_LSB +: ARITH_N]),
        .wr_cause  (wr_data[CAUSE_LSB +: EXC_N]),
        .op_start  (op_start),
        .exc_in    (exc_bits),
        .flag_q    (flag_q),
        .enable_q  (enable_q),
        .cause_q   (cause_q)
    );

    fpsc_trap #(.AN(ARITH_N)) u_trap (
        .cause  (cause_q),
        .enable (enable_q),
        .trap   (trap_req)
    );

    // Assemble the read word from the stored fields.
    always_comb begin
        rd_data                         = '0;
        rd_data[RND_LSB +: RND_W]       = cfg_round;
        rd_data[FLAG_LSB +: ARITH_N]    = flag_q;
        rd_data[EN_LSB +: ARITH_N]      = enable_q;
        rd_data[CAUSE_LSB +: EXC_N]     = cause_q;
        rd_data[DNRM_BIT]               = 1'b1;
        rd_data[PREC_BIT]               = cfg_double;
        rd_data[XFER_BIT]               = cfg_wide;
        rd_data[NAN_BIT]                = cfg_snan;
    end

    AST_RSV_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[RND_LSB + RND_W - 1]) |=> round_reserved); // R10
    AST_ERR_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_ERR && exc_bits[EXC_N-1]) |=> trap_req); // R9
endmodule

// File: tb/fp_status_ctrl_bench.sv
module fp_status_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, n_wr_en = 1'b0;
    logic [31:0] wr_data = '0, n_wr_data = '0;
    logic        op_start = 1'b0, n_op_start = 1'b0;
    logic [5:0]  exc_bits = '0, n_exc_bits = '0;
    logic [31:0] rd_data, n_rd_data;
    logic        trap_req, n_trap_req, round_reserved, n_round_reserved;
    logic [1:0]  cfg_round, n_cfg_round;
    logic        cfg_double, cfg_wide, cfg_snan, n_cfg_double, n_cfg_wide, n_cfg_snan;
    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;

    always #5 clk = ~clk;   // 100 MHz

    fp_status_ctrl #(.HAS_ERR(1'b1)) u_fp_status_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_start(op_start), .exc_bits(exc_bits), .rd_data(rd_data),
        .trap_req(trap_req), .round_reserved(round_reserved), .cfg_round(cfg_round),
        .cfg_double(cfg_double), .cfg_wide(cfg_wide), .cfg_snan(cfg_snan));

    fp_status_ctrl #(.HAS_ERR(1'b0)) u_fp_status_ctrl_noerr (
        .clk(clk), .rst_n(rst_n), .wr_en(n_wr_en), .wr_data(n_wr_data),
        .op_start(n_op_start), .exc_bits(n_exc_bits), .rd_data(n_rd_data),
        .trap_req(n_trap_req), .round_reserved(n_round_reserved), .cfg_round(n_cfg_round),
        .cfg_double(n_cfg_double), .cfg_wide(n_cfg_wide), .cfg_snan(n_cfg_snan));

    typedef struct packed {
        logic [3:0]  tag;
        logic        wr;
        logic [31:0] wd;
        logic        op;
        logic [5:0]  exc;
        logic [31:0] rd;
        logic        trap;
        logic        rsv;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b0, 32'h0000_0000, 1'b0, 6'h00, 32'h0004_0001, 1'b0, 1'b0}, // R1 idle after reset
        '{4'd2,  1'b1, 32'hFFFF_FFFF, 1'b0, 6'h00, 32'h005F_FFFF, 1'b1, 1'b1}, // R2 R9 all ones
        '{4'd3,  1'b1, 32'h0000_0000, 1'b0, 6'h00, 32'h0004_0000, 1'b0, 1'b0}, // R3 zero write
        '{4'd4,  1'b1, 32'h0000_0400, 1'b0, 6'h00, 32'h0004_0400, 1'b0, 1'b0}, // R4 enable Z
        '{4'd9,  1'b0, 32'h0000_0000, 1'b0, 6'h08, 32'h0004_8420, 1'b1, 1'b0}, // R9 Z enabled traps
        '{4'd5,  1'b0, 32'h0000_0000, 1'b1, 6'h00, 32'h0004_0420, 1'b0, 1'b0}, // R5 start clears
        '{4'd6,  1'b0, 32'h0000_0000, 1'b0, 6'h01, 32'h0004_1424, 1'b0, 1'b0}, // R6 inexact
        '{4'd8,  1'b0, 32'h0000_0000, 1'b1, 6'h04, 32'h0004_4434, 1'b0, 1'b0}, // R8 start+overflow
        '{4'd9,  1'b0, 32'h0000_0000, 1'b0, 6'h20, 32'h0006_4434, 1'b1, 1'b0}, // R9 error traps
        '{4'd12, 1'b1, 32'h0000_0002, 1'b0, 6'h10, 32'h0005_0042, 1'b0, 1'b1}, // R12 R10 write+invalid
        '{4'd4,  1'b1, 32'h0058_0001, 1'b0, 6'h00, 32'h005C_0001, 1'b0, 1'b0}, // R4 modes
        '{4'd5,  1'b0, 32'h0000_0000, 1'b1, 6'h00, 32'h005C_0001, 1'b0, 1'b0}, // R5 empty start
        '{4'd4,  1'b1, 32'h0058_0801, 1'b0, 6'h00, 32'h005C_0801, 1'b0, 1'b0}, // R4 enable V
        '{4'd7,  1'b0, 32'h0000_0000, 1'b0, 6'h12, 32'h005D_2849, 1'b1, 1'b0}  // R7 R6 V+U
    };

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset word", rd_data, 32'h0004_0001);
        check("R1", "reset trap", {31'b0, trap_req}, 32'h0);

        // Vector walk on the full-featured copy.
        for (int i = 0; i < NV; i++) begin
            wr_en    = VEC[i].wr;
            wr_data  = VEC[i].wd;
            op_start = VEC[i].op;
            exc_bits = VEC[i].exc;
            @(negedge clk);
            wr_en = 1'b0; op_start = 1'b0; exc_bits = '0;
            check($sformatf("R%0d v%0d", VEC[i].tag, i), "rd_data", rd_data, VEC[i].rd);
            check($sformatf("R%0d v%0d", VEC[i].tag, i), "trap_req", {31'b0, trap_req}, {31'b0, VEC[i].trap});
            check($sformatf("R%0d v%0d", VEC[i].tag, i), "round_reserved", {31'b0, round_reserved}, {31'b0, VEC[i].rsv});
        end

        // R4 mode outputs after the walk: round 01, precision, transfer and NaN set.
        check("R4", "cfg outputs", {27'b0, cfg_round, cfg_double, cfg_wide, cfg_snan}, 32'h0000_000F);

        // R11 variant without error support.
        n_exc_bits = 6'h3F;
        @(negedge clk);
        n_exc_bits = '0;
        check("R11", "noerr all events", n_rd_data, 32'h0005_F07D);
        check("R11", "noerr trap", {31'b0, n_trap_req}, 32'h0);
        n_wr_en = 1'b1; n_wr_data = 32'h0002_0000;
        @(negedge clk);
        n_wr_en = 1'b0;
        check("R11", "noerr error write", n_rd_data, 32'h0004_0000);
        n_wr_en = 1'b1; n_wr_data = 32'h0000_0F80;
        @(negedge clk);
        n_wr_en = 1'b0; n_exc_bits = 6'h20;
        @(negedge clk);
        n_exc_bits = '0;
        check("R11", "noerr error event", n_rd_data, 32'h0004_0F80);
        check("R11", "noerr error no trap", {31'b0, n_trap_req}, 32'h0);

        // R10 code 11 stored and flagged, then code 00 clears the flag.
        wr_en = 1'b1; wr_data = 32'h0000_0003;
        @(negedge clk);
        check("R10", "code 11 flagged", {30'b0, round_reserved, cfg_round[1]}, 32'h3);
        wr_data = 32'h0000_0000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10", "code 00 clean", {31'b0, round_reserved}, 32'h0);

        // R1 reset in mid-run restores the reset word.
        wr_en = 1'b1; wr_data = 32'h0040_0FFF;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "mid-run reset", rd_data, 32'h0004_0001);
        check("R1", "mid-run reset noerr", n_rd_data, 32'h0004_0001);

        finish_run();
    end
endmodule